// File: doc/BRIEF.md
# Virtual-8086 Software Interrupt Redirection Unit

This unit decides what happens to a software interrupt raised while the processor runs 8086-style code in virtual mode. When the virtual-mode extension is off, the I/O privilege level alone picks between the protected-mode gate path and a general-protection fault. When the extension is on, a per-vector bit in a bitmap held in the task-state segment makes the choice. A clear bit sends the interrupt to a real-mode style handler. In that case the unit reads the handler's IP and CS from the vector table at linear address zero, pushes a three-word 16-bit frame and produces the new code segment, instruction pointer, stack pointer and flags.

A single request/acknowledge memory port carries every access: the bitmap base word, the bitmap byte, the two vector-table words and the three frame writes. The caller pulses `start` with the operands valid. It then waits for `done`, which comes with a two-bit outcome code. The protected-mode gate path lies outside this unit, which only reports that the interrupt must go there.

Top module: `vint_redirect`

## Requirements
- R1: With `ext_en` low, the unit makes no memory access. It reports outcome 2 (protected path) when `iopl` is 3, and outcome 3 (fault, error code zero) otherwise.
- R2: With `ext_en` high, the first access is a word read at `tss_base`+102. Subtract 32 from that word modulo 65536 to get a bitmap offset. The second access is a byte read (`mem_wide`=0, data in `mem_rdata[7:0]`) at `tss_base` + offset + vector/8. Bit vector mod 8 of that byte is the bitmap bit.
- R3: A bitmap bit of 1 ends the sequence with no writes. The outcome is 2 when `iopl` is 3 and 3 otherwise.
- R4: A bitmap bit of 0 gives outcome 1 (redirect). The new IP is the word read at linear address vector*4 and the new CS is the word read at vector*4+2.
- R5: A redirect writes three 16-bit words, in order: flags image, old CS, then next IP. Before each write, SP is decremented by 2 modulo 65536, and the write goes to `ss_base` + SP. `new_sp` ends at `sp_in`-6 modulo 65536.
- R6: The flags image is the low 16 bits of `flags_in`. When `iopl` is below 3, bit 9 of the image is replaced by flag bit 19 and bits 13:12 of the image are forced to 3.
- R7: After a redirect, `new_cs_base` equals the new CS shifted left by 4 (20 bits).
- R8: After a redirect, `flags_out` equals `flags_in` with bits 8 and 16 cleared. Bit 9 is also cleared when `iopl` is 3, and bit 19 is cleared otherwise. On the other outcomes, `flags_out`, `new_cs`, `new_ip` and `new_sp` equal `flags_in`, `cs_in`, `ip_next` and `sp_in`.
- R9: After reset, `done` and `outcome` are 0. `done` is a one-cycle pulse. `outcome` and the result outputs hold their values until the next `start`.
- R10: A memory request keeps its address, direction and width stable until it is acknowledged. Writes are always 16 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin handling one interrupt |
| vector | input | 8 | Interrupt vector |
| ext_en | input | 1 | Virtual-mode extension enable |
| iopl | input | 2 | Current I/O privilege level |
| flags_in | input | 32 | Current flags |
| cs_in | input | 16 | Current CS selector |
| ip_next | input | 16 | IP of the following instruction |
| sp_in | input | 16 | Current 16-bit stack pointer |
| ss_base | input | ADDR_W | Stack segment linear base |
| tss_base | input | ADDR_W | Task-state segment linear base |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | 1 = 16-bit access, 0 = byte read |
| mem_addr | output | ADDR_W | Linear address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with ack |
| mem_ack | input | 1 | Access completed |
| done | output | 1 | One-cycle completion pulse |
| outcome | output | 2 | 1 redirect, 2 protected path, 3 fault |
| new_cs | output | 16 | Resulting CS selector |
| new_cs_base | output | 20 | Resulting CS base |
| new_ip | output | 16 | Resulting IP |
| new_sp | output | 16 | Resulting SP |
| flags_out | output | 32 | Resulting flags |

## Verification
Several directed cases target the bitmap lookup. Vectors 0xFE and 0xFF share one bitmap byte but take different routes, so a unit that picked the wrong bit within the byte would swap their outcomes. A bitmap base word smaller than 32 checks that the subtraction wraps in 16 bits; a unit that carried the borrow into the upper address bits would read the wrong location. A stack pointer of 2 makes the frame straddle the 64K wrap, which exposes any push address formed with a carry. Redirects are run at IOPL 3 and at IOPL below 3, so an inverted IF/VIF substitution or clearing rule shows up both in the pushed image and in `flags_out`.

// File: rtl/vint_pkg.sv
package vint_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_BASE, ST_RD_BIT, ST_RD_IP, ST_RD_CS,
    ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP, ST_DONE
  } vint_state_e;

  typedef enum logic [1:0] {
    OC_NONE  = 2'd0,
    OC_REDIR = 2'd1,
    OC_PROT  = 2'd2,
    OC_FAULT = 2'd3
  } vint_outcome_e;

  localparam int FL_TF      = 8;
  localparam int FL_IF      = 9;
  localparam int FL_IOPL_LO = 12;
  localparam int FL_RF      = 16;
  localparam int FL_VIF     = 19;

  localparam logic [15:0] TSS_BMP_PTR_OFS = 16'd102;
  localparam logic [15:0] BMP_BIAS        = 16'd32;
endpackage

// File: rtl/vint_ctrl.sv
module vint_ctrl
  import vint_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ext_en,
  input  logic          iopl_max_now,
  input  logic          iopl_max_lat,
  input  logic          acc_done,
  input  logic          bmp_bit,
  output vint_state_e   state,
  output vint_outcome_e outcome
);
  vint_state_e   state_nx;
  vint_outcome_e outcome_nx;

  always_comb begin
    state_nx   = state;
    outcome_nx = outcome;
    case (state)
      ST_IDLE: begin
        if (start) begin
          outcome_nx = OC_NONE;
          if (!ext_en) begin
            state_nx   = ST_DONE;
            outcome_nx = iopl_max_now ? OC_PROT : OC_FAULT;
          end else begin
            state_nx = ST_RD_BASE;
          end
        end
      end
      ST_RD_BASE: if (acc_done) state_nx = ST_RD_BIT;
      ST_RD_BIT: begin
        if (acc_done) begin
          if (bmp_bit) begin
            state_nx   = ST_DONE;
            outcome_nx = iopl_max_lat ? OC_PROT : OC_FAULT;
          end else begin
            state_nx = ST_RD_IP;
          end
        end
      end
      ST_RD_IP:   if (acc_done) state_nx = ST_RD_CS;
      ST_RD_CS:   if (acc_done) state_nx = ST_PUSH_FL;
      ST_PUSH_FL: if (acc_done) state_nx = ST_PUSH_CS;
      ST_PUSH_CS: if (acc_done) state_nx = ST_PUSH_IP;
      ST_PUSH_IP: begin
        if (acc_done) begin
          state_nx   = ST_DONE;
          outcome_nx = OC_REDIR;
        end
      end
      ST_DONE: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      outcome <= OC_NONE;
    end else begin
      state   <= state_nx;
      outcome <= outcome_nx;
    end
  end
endmodule

// File: rtl/vint_flags.sv
module vint_flags
  import vint_pkg::*;
#(
  parameter int FLAG_W = 32
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic              iopl_max,
  output logic [15:0]       image,
  output logic [FLAG_W-1:0] updated
);
  always_comb begin
    image = flags[15:0];
    if (!iopl_max) begin
      image[FL_IF]                  = flags[FL_VIF];
      image[FL_IOPL_LO+1:FL_IOPL_LO] = 2'b11;
    end
  end

  always_comb begin
    updated        = flags;
    updated[FL_TF] = 1'b0;
    updated[FL_RF] = 1'b0;
    if (iopl_max) updated[FL_IF]  = 1'b0;
    else          updated[FL_VIF] = 1'b0;
  end
endmodule

// File: rtl/vint_port.sv
module vint_port
  import vint_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  vint_state_e       state,
  input  logic [ADDR_W-1:0] tss_base,
  input  logic [ADDR_W-1:0] ss_base,
  input  logic [15:0]       bmp_ofs,
  input  logic [7:0]        vec,
  input  logic [15:0]       sp_dec,
  input  logic [15:0]       image,
  input  logic [15:0]       old_cs,
  input  logic [15:0]       old_ip,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata
);
  localparam int PAD16 = ADDR_W - 16;
  localparam int PADV  = ADDR_W - 10;
  localparam int PADB  = ADDR_W - 5;

  logic [ADDR_W-1:0] ivt_addr;
  logic [ADDR_W-1:0] push_addr;

  assign ivt_addr  = {{PADV{1'b0}}, vec, 2'b00};
  assign push_addr = ss_base + {{PAD16{1'b0}}, sp_dec};

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_wide  = 1'b1;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_RD_BASE: mem_addr = tss_base + {{PAD16{1'b0}}, TSS_BMP_PTR_OFS};
      ST_RD_BIT: begin
        mem_wide = 1'b0;
        mem_addr = tss_base + {{PAD16{1'b0}}, bmp_ofs} + {{PADB{1'b0}}, vec[7:3]};
      end
      ST_RD_IP: mem_addr = ivt_addr;
      ST_RD_CS: mem_addr = ivt_addr + {{(ADDR_W-2){1'b0}}, 2'd2};
      ST_PUSH_FL: begin
        mem_we = 1'b1; mem_addr = push_addr; mem_wdata = image;
      end
      ST_PUSH_CS: begin
        mem_we = 1'b1; mem_addr = push_addr; mem_wdata = old_cs;
      end
      ST_PUSH_IP: begin
        mem_we = 1'b1; mem_addr = push_addr; mem_wdata = old_ip;
      end
      default: mem_req = 1'b0;
    endcase
  end
endmodule

// File: rtl/vint_redirect.sv
module vint_redirect
  import vint_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        vector,
  input  logic              ext_en,
  input  logic [1:0]        iopl,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [15:0]       cs_in,
  input  logic [15:0]       ip_next,
  input  logic [15:0]       sp_in,
  input  logic [ADDR_W-1:0] ss_base,
  input  logic [ADDR_W-1:0] tss_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              done,
  output logic [1:0]        outcome,
  output logic [15:0]       new_cs,
  output logic [19:0]       new_cs_base,
  output logic [15:0]       new_ip,
  output logic [15:0]       new_sp,
  output logic [FLAG_W-1:0] flags_out
);
  vint_state_e   st;
  vint_outcome_e oc;

  logic [7:0]        vec_q,   vec_nx;
  logic              pl3_q,   pl3_nx;
  logic [FLAG_W-1:0] flg_q,   flg_nx;
  logic [15:0]       ocs_q,   ocs_nx;
  logic [15:0]       oip_q,   oip_nx;
  logic [ADDR_W-1:0] ssb_q,   ssb_nx;
  logic [ADDR_W-1:0] tsb_q,   tsb_nx;
  logic [15:0]       bmp_q,   bmp_nx;
  logic [15:0]       sp_q,    sp_nx;
  logic [15:0]       ncs_q,   ncs_nx;
  logic [15:0]       nip_q,   nip_nx;

  logic              cap_en;
  logic              acc_done;
  logic              bmp_bit;
  logic [15:0]       sp_dec;
  logic [15:0]       image;
  logic [FLAG_W-1:0] flg_upd;

  assign cap_en   = (st == ST_IDLE) && start;
  assign acc_done = mem_req && mem_ack;
  assign bmp_bit  = mem_rdata[vec_q[2:0]];
  assign sp_dec   = sp_q - 16'd2;

  vint_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .ext_en       (ext_en),
    .iopl_max_now (iopl == 2'd3),
    .iopl_max_lat (pl3_q),
    .acc_done     (acc_done),
    .bmp_bit      (bmp_bit),
    .state        (st),
    .outcome      (oc)
  );

  vint_flags #(.FLAG_W(FLAG_W)) u_flags (
    .flags    (flg_q),
    .iopl_max (pl3_q),
    .image    (image),
    .updated  (flg_upd)
  );

  vint_port #(.ADDR_W(ADDR_W)) u_port (
    .state     (st),
    .tss_base  (tsb_q),
    .ss_base   (ssb_q),
    .bmp_ofs   (bmp_q),
    .vec       (vec_q),
    .sp_dec    (sp_dec),
    .image     (image),
    .old_cs    (ocs_q),
    .old_ip    (oip_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wide  (mem_wide),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  always_comb begin
    vec_nx = vec_q;  pl3_nx = pl3_q;  flg_nx = flg_q;
    ocs_nx = ocs_q;  oip_nx = oip_q;  ssb_nx = ssb_q;
    tsb_nx = tsb_q;  bmp_nx = bmp_q;  sp_nx  = sp_q;
    ncs_nx = ncs_q;  nip_nx = nip_q;
    if (cap_en) begin
      vec_nx = vector;   pl3_nx = (iopl == 2'd3);  flg_nx = flags_in;
      ocs_nx = cs_in;    oip_nx = ip_next;         ssb_nx = ss_base;
      tsb_nx = tss_base; sp_nx  = sp_in;
      ncs_nx = cs_in;    nip_nx = ip_next;
    end
    if (acc_done) begin
      case (st)
        ST_RD_BASE: bmp_nx = mem_rdata - BMP_BIAS;
        ST_RD_IP:   nip_nx = mem_rdata;
        ST_RD_CS:   ncs_nx = mem_rdata;
        ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP: sp_nx = sp_dec;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0; pl3_q <= 1'b0; flg_q <= '0; ocs_q <= '0; oip_q <= '0;
      ssb_q <= '0; tsb_q <= '0;   bmp_q <= '0; sp_q  <= '0;
      ncs_q <= '0; nip_q <= '0;
    end else begin
      vec_q <= vec_nx; pl3_q <= pl3_nx; flg_q <= flg_nx; ocs_q <= ocs_nx;
      oip_q <= oip_nx; ssb_q <= ssb_nx; tsb_q <= tsb_nx; bmp_q <= bmp_nx;
      sp_q  <= sp_nx;  ncs_q <= ncs_nx; nip_q <= nip_nx;
    end
  end

  assign done        = (st == ST_DONE);
  assign outcome     = oc;
  assign new_cs      = ncs_q;
  assign new_cs_base = {ncs_q, 4'h0};
  assign new_ip      = nip_q;
  assign new_sp      = sp_q;
  assign flags_out   = (oc == OC_REDIR) ? flg_upd : flg_q;
endmodule

// File: rtl/vint_redirect_chk.sv
module vint_redirect_chk #(
  parameter int ADDR_W = 32,
  parameter int FLAG_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [1:0]        outcome,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_wide,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [15:0]       new_sp,
  input logic [FLAG_W-1:0] flags_out
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_HAS_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> outcome != 2'd0); // R9

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wide))); // R10

  AST_WRITE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wide); // R10

  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (new_sp == $past(new_sp) - 16'd2)); // R5

  AST_REDIR_TRACE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && outcome == 2'd1) |-> (!flags_out[8] && !flags_out[16])); // R8
endmodule

bind vint_redirect vint_redirect_chk #(.ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .outcome   (outcome),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wide  (mem_wide),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack),
  .new_sp    (new_sp),
  .flags_out (flags_out)
);

// File: tb/vint_redirect_tb.sv
module vint_redirect_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  vector;
  logic        ext_en;
  logic [1:0]  iopl;
  logic [31:0] flags_in;
  logic [15:0] cs_in, ip_next, sp_in;
  logic [31:0] ss_base, tss_base;
  logic        mem_req, mem_we, mem_wide;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_ack;
  logic        done;
  logic [1:0]  outcome;
  logic [15:0] new_cs, new_ip, new_sp;
  logic [19:0] new_cs_base;
  logic [31:0] flags_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  vint_redirect u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vector(vector), .ext_en(ext_en),
    .iopl(iopl), .flags_in(flags_in), .cs_in(cs_in), .ip_next(ip_next),
    .sp_in(sp_in), .ss_base(ss_base), .tss_base(tss_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .done(done), .outcome(outcome), .new_cs(new_cs),
    .new_cs_base(new_cs_base), .new_ip(new_ip), .new_sp(new_sp),
    .flags_out(flags_out)
  );

  // small memory model, indexed by the low 12 address bits
  logic [7:0]  mem [0:4095];
  int          wr_cnt, rd_cnt;
  logic [31:0] wr_addr [0:7];
  logic [15:0] wr_data [0:7];
  logic [31:0] rd_addr [0:7];

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[11:0]]         <= mem_wdata[7:0];
        mem[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
        if (wr_cnt < 8) begin
          wr_addr[wr_cnt] <= mem_addr;
          wr_data[wr_cnt] <= mem_wdata;
        end
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem_wide ? {mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]}
                              : {8'h00, mem[mem_addr[11:0]]};
        if (rd_cnt < 8) rd_addr[rd_cnt] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] vt_ip(input logic [7:0] v);
    return 16'h1000 + {8'h00, v} * 16'd3;
  endfunction
  function automatic logic [15:0] vt_cs(input logic [7:0] v);
    return 16'h3000 + {8'h00, v} * 16'd5;
  endfunction

  task automatic put_word(input logic [31:0] a, input logic [15:0] d);
    mem[a[11:0]]         = d[7:0];
    mem[a[11:0] + 12'd1] = d[15:8];
  endtask

  function automatic logic [31:0] bmp_byte_addr(input logic [15:0] word, input logic [7:0] v);
    return tss_base + {16'h0, word - 16'd32} + {27'h0, v[7:3]};
  endfunction

  task automatic set_bmp(input logic [15:0] word, input logic [7:0] v, input logic b);
    logic [31:0] a;
    a = bmp_byte_addr(word, v);
    mem[a[11:0]][v[2:0]] = b;
  endtask

  task automatic run(input logic [7:0] v, input logic e, input logic [1:0] pl,
                     input logic [31:0] fl, input logic [15:0] cs, input logic [15:0] ip,
                     input logic [15:0] sp, output logic got);
    @(negedge clk);
    vector = v; ext_en = e; iopl = pl; flags_in = fl;
    cs_in = cs; ip_next = ip; sp_in = sp;
    wr_cnt = 0; rd_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 80 && !got; i++) begin
      if (done) got = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R9", "done after reset", {31'h0, done}, 32'h0);
    check("R9", "outcome after reset", {30'h0, outcome}, 32'h0);
    check("R10", "no request after reset", {31'h0, mem_req}, 32'h0);
  endtask

  task automatic t_ext_off;
    logic got;
    run(8'h21, 1'b0, 2'd3, 32'h0000_3202, 16'h1111, 16'h2222, 16'h0100, got);
    check("R1", "done seen", {31'h0, got}, 32'h1);
    check("R1", "ext off iopl3 outcome", {30'h0, outcome}, 32'd2);
    check("R1", "ext off no reads", rd_cnt, 0);
    check("R8", "flags unchanged on hand-off", flags_out, 32'h0000_3202);
    check("R8", "sp unchanged on hand-off", {16'h0, new_sp}, 32'h0100);
    @(negedge clk);
    check("R9", "done one cycle", {31'h0, done}, 32'h0);
    check("R9", "outcome held", {30'h0, outcome}, 32'd2);
    run(8'h21, 1'b0, 2'd1, 32'h0000_1202, 16'h1111, 16'h2222, 16'h0100, got);
    check("R1", "ext off iopl1 outcome", {30'h0, outcome}, 32'd3);
    check("R1", "ext off no writes", wr_cnt, 0);
  endtask

  task automatic t_bitmap_set;
    logic got;
    run(8'h21, 1'b1, 2'd3, 32'h0000_3202, 16'h1234, 16'h5678, 16'h0200, got);
    check("R3", "bit set iopl3 outcome", {30'h0, outcome}, 32'd2);
    check("R3", "bit set no writes", wr_cnt, 0);
    check("R2", "base word address", rd_addr[0], tss_base + 32'd102);
    check("R2", "bitmap byte address", rd_addr[1], bmp_byte_addr(16'h0088, 8'h21));
    check("R8", "cs unchanged on hand-off", {16'h0, new_cs}, 32'h1234);
    check("R8", "ip unchanged on hand-off", {16'h0, new_ip}, 32'h5678);
    run(8'hFF, 1'b1, 2'd0, 32'h0000_0202, 16'h1234, 16'h5678, 16'h0200, got);
    check("R3", "bit set iopl0 faults", {30'h0, outcome}, 32'd3);
    check("R3", "fault makes two reads only", rd_cnt, 2);
  endtask

  task automatic t_redirect(input logic [7:0] v, input logic [1:0] pl, input logic [31:0] fl,
                            input logic [15:0] sp, input logic [15:0] word);
    logic        got;
    logic [15:0] img;
    logic [31:0] fexp;
    logic [15:0] s1, s2, s3;
    run(v, 1'b1, pl, fl, 16'hABCD, 16'h0F0E, sp, got);
    img = fl[15:0];
    if (pl != 2'd3) begin img[9] = fl[19]; img[13:12] = 2'b11; end
    fexp = fl; fexp[8] = 1'b0; fexp[16] = 1'b0;
    if (pl == 2'd3) fexp[9] = 1'b0; else fexp[19] = 1'b0;
    s1 = sp - 16'd2; s2 = sp - 16'd4; s3 = sp - 16'd6;
    check("R4", "redirect outcome", {30'h0, outcome}, 32'd1);
    check("R2", "bitmap byte address", rd_addr[1], bmp_byte_addr(word, v));
    check("R4", "ip read address", rd_addr[2], {22'h0, v, 2'b00});
    check("R4", "cs read address", rd_addr[3], {22'h0, v, 2'b00} + 32'd2);
    check("R4", "new ip", {16'h0, new_ip}, {16'h0, vt_ip(v)});
    check("R4", "new cs", {16'h0, new_cs}, {16'h0, vt_cs(v)});
    check("R7", "new cs base", {12'h0, new_cs_base}, {12'h0, vt_cs(v), 4'h0});
    check("R5", "three writes", wr_cnt, 3);
    check("R5", "flags push addr", wr_addr[0], ss_base + {16'h0, s1});
    check("R5", "cs push addr", wr_addr[1], ss_base + {16'h0, s2});
    check("R5", "ip push addr", wr_addr[2], ss_base + {16'h0, s3});
    check("R6", "flags image", {16'h0, wr_data[0]}, {16'h0, img});
    check("R5", "cs pushed", {16'h0, wr_data[1]}, 32'hABCD);
    check("R5", "ip pushed", {16'h0, wr_data[2]}, 32'h0F0E);
    check("R5", "final sp", {16'h0, new_sp}, {16'h0, s3});
    check("R8", "flags out", flags_out, fexp);
  endtask

  task automatic t_redirect_low_iopl;
    t_redirect(8'h13, 2'd1, 32'h0009_1100, 16'h0100, 16'h0088);
  endtask

  task automatic t_redirect_shared_byte;
    t_redirect(8'hFE, 2'd3, 32'h0008_3342, 16'h0200, 16'h0088);
  endtask

  task automatic t_sp_wrap;
    t_redirect(8'h00, 2'd0, 32'h0000_0146, 16'h0002, 16'h0088);
  endtask

  task automatic t_base_wrap;
    put_word(tss_base + 32'd102, 16'h0010);
    set_bmp(16'h0010, 8'h40, 1'b0);
    t_redirect(8'h40, 2'd2, 32'h0008_2200, 16'h0300, 16'h0010);
    put_word(tss_base + 32'd102, 16'h0088);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    tss_base = 32'h0000_0800;
    ss_base  = 32'h0000_0C00;
    put_word(tss_base + 32'd102, 16'h0088);
    for (int v = 0; v < 256; v++) begin
      put_word({22'h0, 8'(v), 2'b00}, vt_ip(8'(v)));
      put_word({22'h0, 8'(v), 2'b00} + 32'd2, vt_cs(8'(v)));
    end
    set_bmp(16'h0088, 8'h21, 1'b1);
    set_bmp(16'h0088, 8'hFF, 1'b1);
    rst_n = 1'b0; start = 1'b0; vector = '0; ext_en = 1'b0; iopl = '0;
    flags_in = '0; cs_in = '0; ip_next = '0; sp_in = '0;
    mem_rdata = '0; mem_ack = 1'b0; wr_cnt = 0; rd_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ext_off();
    t_bitmap_set();
    t_redirect_low_iopl();
    t_redirect_shared_byte();
    t_sp_wrap();
    t_base_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule